// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Initializer

This block owns the refresh duty for an asynchronous DRAM with 1024 rows. After reset it holds the memory idle for a power-up pause. It then runs a burst of refresh cycles, and only after that does it let the access controller in. From then on, an interval timer marks each distributed refresh as owed. The scheduler pays these refreshes back as CAS-before-RAS cycles, which use the device's own row counter, or as RAS-only cycles, which use a row counter kept inside the block. An input chooses between the two forms when each refresh starts.

The access controller asks for the memory with a request line. It keeps the memory for as long as the request is held and gets a grant in return. An owed refresh waits until the current access ends. If the number of owed refreshes reaches a set limit, the refresh goes ahead of the next access. A sleep request places the memory in self refresh. The block first runs one refresh, then enters self refresh with CAS leading RAS, and keeps RAS low for at least a minimum time. On exit it applies a longer precharge and runs one more refresh straight away. The write-enable strobe is held high at all times, so a CAS-before-RAS cycle can never be taken as a test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, ras_n and cas_n are 1, acc_gnt is 0, init_done is 0, sleep_ack is 0 and ref_busy is 1.
- R2: After reset is released, ras_n stays 1 for at least PAUSE_CYC clock cycles.
- R3: After the pause, exactly INIT_REFS refresh cycles complete before init_done rises. acc_gnt is never 1 while init_done is 0, even if acc_req is held high from reset.
- R4: In a CAS-before-RAS refresh, cas_n goes low at least T_CSR cycles before ras_n falls and stays low for as long as ras_n is low. ras_n is low for exactly T_RAS cycles. ras_n then stays high for at least T_RP cycles before it falls again.
- R5: In RAS-only mode (ras_only_sel = 1 when a refresh starts), cas_n stays 1 while ras_n is low. row_addr holds steady while ras_n is low. Each RAS-only refresh presents the previous row plus 1, and the row wraps from 1023 to 0.
- R6: With no access and no sleep request, one refresh is issued for every REF_INTERVAL cycles.
- R7: While acc_gnt is 1, ras_n and cas_n are both 1. A refresh that comes due during an access starts only after acc_req drops, and the grant is given only while no refresh is due, or while the owed count is below FORCE_LIM and acc_req is high.
- R8: When the owed-refresh count reaches FORCE_LIM, a refresh is issued at the next idle cycle even if acc_req is high. Back-to-back accesses therefore cannot starve refresh.
- R9: On sleep_req, a refresh completes within REF_INTERVAL cycles before self refresh begins. Self refresh lowers cas_n at least T_CSR cycles before ras_n and holds ras_n low for at least SELF_MIN cycles, with sleep_ack at 1 throughout. On exit, ras_n stays high for at least T_RPS cycles, and the next refresh begins within REF_INTERVAL cycles of ras_n rising.
- R10: we_n is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access controller wants the memory; held for the whole access |
| sleep_req | input | 1 | Request to enter self refresh; dropping it exits |
| ras_only_sel | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS, sampled when a refresh starts |
| ras_n | output | 1 | Row strobe from the refresh path, active low |
| cas_n | output | 1 | Column strobe from the refresh path, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Row presented during RAS-only refresh |
| ref_busy | output | 1 | Refresh path owns the memory strobes |
| acc_gnt | output | 1 | Access controller may drive the memory |
| init_done | output | 1 | Power-up pause and initial burst are finished |
| sleep_ack | output | 1 | Memory is in self refresh |

## Verification
The assertions assume that the access controller keeps acc_req high until it has finished with the memory. They also assume that no other agent moves the block's strobes. Under those conditions, RAS and CAS activity and the grant never overlap. The stimulus follows a request-then-hold discipline in every phase: it raises acc_req, waits for acc_gnt, holds the access for a random 1 to 30 cycles, then releases it. Each access therefore stays below the refresh interval. sleep_req is only raised while no access is pending and is held longer than SELF_MIN. ras_only_sel is changed only in idle stretches.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;
  typedef enum logic [3:0] {
    S_PAUSE, S_IDLE, S_ACC, S_CSR, S_RLO, S_PRE, S_SR_CAS, S_SR_LOW, S_SR_PRE
  } rs_state_t;

  typedef enum logic [1:0] {
    W_NORM, W_PRE_SLP, W_POST_SLP
  } rs_why_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfs_tick.sv
module rfs_tick #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int unsigned W = $clog2(PERIOD);
  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = (cnt == W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= en && wrap;
      if (en) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_owed.sv
module rfs_owed #(
  parameter int unsigned OWED_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  input  logic              dec,
  output logic [OWED_W-1:0] owed
);
  localparam logic [OWED_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      owed <= '0;
    end else if (inc && !dec) begin
      if (owed != TOP) owed <= owed + 1'b1;
    end else if (dec && !inc) begin
      if (owed != '0) owed <= owed - 1'b1;
    end
  end
endmodule

// File: rtl/rfs_row.sv
module rfs_row #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (inc) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import ref_sched_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned INIT_REFS    = 8,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned OWED_W       = 4,
  parameter int unsigned FORCE_LIM    = 4,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RAS        = 6,
  parameter int unsigned T_RP         = 5,
  parameter int unsigned T_RPS        = 11,
  parameter int unsigned SELF_MIN     = 10000,
  parameter int unsigned ROW_W        = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_req,
  input  logic             sleep_req,
  input  logic             ras_only_sel,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             ref_busy,
  output logic             acc_gnt,
  output logic             init_done,
  output logic             sleep_ack
);
  localparam int unsigned TMR_MAX = max_of(max_of(PAUSE_CYC, SELF_MIN),
                                    max_of(max_of(T_RAS, T_RP), max_of(T_RPS, T_CSR)));
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned INIT_W  = $clog2(INIT_REFS + 1);

  rs_state_t         st, st_n;
  rs_why_t           why_q, why_n;
  logic [TMR_W-1:0]  tmr, tmr_n;
  logic              ro_q, ro_n;
  logic [INIT_W-1:0] init_cnt;
  logic [OWED_W-1:0] owed;
  logic              tick, row_inc, ref_done, go_ref, force_ref, last_init, in_sr;
  rs_why_t           go_why;

  assign we_n      = 1'b1;
  assign force_ref = (owed >= OWED_W'(FORCE_LIM));
  assign last_init = (init_cnt == INIT_W'(INIT_REFS - 1));
  assign in_sr     = (st == S_SR_CAS) || (st == S_SR_LOW) || (st == S_SR_PRE);

  rfs_tick #(.PERIOD(REF_INTERVAL)) u_tick (
    .clk(clk), .rst(rst), .en(init_done && !in_sr), .clr(st == S_SR_LOW), .tick(tick)
  );

  rfs_owed #(.OWED_W(OWED_W)) u_owed (
    .clk(clk), .rst(rst), .clr(st == S_SR_LOW), .inc(tick),
    .dec(ref_done && init_done), .owed(owed)
  );

  rfs_row #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .inc(row_inc), .row(row_addr)
  );

  always_comb begin
    st_n     = st;
    why_n    = why_q;
    ro_n     = ro_q;
    tmr_n    = (tmr != '0) ? tmr - 1'b1 : '0;
    row_inc  = 1'b0;
    ref_done = 1'b0;
    go_ref   = 1'b0;
    go_why   = W_NORM;
    unique case (st)
      S_PAUSE: if (tmr == '0) go_ref = 1'b1;
      S_IDLE: begin
        if (force_ref || (owed != '0 && !acc_req)) begin
          go_ref = 1'b1;
        end else if (sleep_req) begin
          go_ref = 1'b1;
          go_why = W_PRE_SLP;
        end else if (acc_req) begin
          st_n = S_ACC;
        end
      end
      S_ACC: if (!acc_req) st_n = S_IDLE;
      S_CSR: if (tmr == '0) begin
        st_n  = S_RLO;
        tmr_n = TMR_W'(T_RAS - 1);
      end
      S_RLO: if (tmr == '0) begin
        st_n    = S_PRE;
        tmr_n   = TMR_W'(T_RP - 1);
        row_inc = ro_q;
      end
      S_PRE: if (tmr == '0) begin
        ref_done = 1'b1;
        if (!init_done && !last_init) begin
          go_ref = 1'b1;
        end else if (why_q == W_PRE_SLP) begin
          st_n  = S_SR_CAS;
          tmr_n = TMR_W'(T_CSR - 1);
        end else begin
          st_n = S_IDLE;
        end
      end
      S_SR_CAS: if (tmr == '0) begin
        st_n  = S_SR_LOW;
        tmr_n = TMR_W'(SELF_MIN - 1);
      end
      S_SR_LOW: if (tmr == '0 && !sleep_req) begin
        st_n  = S_SR_PRE;
        tmr_n = TMR_W'(T_RPS - 1);
      end
      S_SR_PRE: if (tmr == '0) begin
        go_ref = 1'b1;
        go_why = W_POST_SLP;
      end
      default: st_n = S_IDLE;
    endcase
    if (go_ref) begin
      why_n = go_why;
      ro_n  = ras_only_sel;
      st_n  = ras_only_sel ? S_RLO : S_CSR;
      tmr_n = ras_only_sel ? TMR_W'(T_RAS - 1) : TMR_W'(T_CSR - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_PAUSE;
      tmr       <= TMR_W'(PAUSE_CYC - 1);
      why_q     <= W_NORM;
      ro_q      <= 1'b0;
      init_cnt  <= '0;
      init_done <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      acc_gnt   <= 1'b0;
      ref_busy  <= 1'b1;
      sleep_ack <= 1'b0;
    end else begin
      st    <= st_n;
      tmr   <= tmr_n;
      why_q <= why_n;
      ro_q  <= ro_n;
      if (ref_done && !init_done) begin
        init_cnt <= init_cnt + 1'b1;
        if (last_init) init_done <= 1'b1;
      end
      ras_n     <= !((st_n == S_RLO) || (st_n == S_SR_LOW));
      cas_n     <= !((st_n == S_CSR) || (st_n == S_SR_CAS) || (st_n == S_SR_LOW) ||
                     ((st_n == S_RLO) && !ro_n));
      acc_gnt   <= (st_n == S_ACC);
      ref_busy  <= !((st_n == S_IDLE) || (st_n == S_ACC));
      sleep_ack <= (st_n == S_SR_LOW);
    end
  end
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned ROW_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr,
  input logic             acc_gnt,
  input logic             init_done,
  input logic             sleep_ack
);
  // R4: CAS only ever falls while RAS is high
  a_r4_cas_falls_ras_high: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> ras_n);

  // R7: the granted controller sees idle strobes
  a_r7_gnt_strobes_idle: assert property (@(posedge clk) disable iff (rst)
    acc_gnt |-> (ras_n && cas_n));

  // R5: row held while RAS stays low
  a_r5_row_stable: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr));

  // R3: no grant before the initial burst ends
  a_r3_no_early_gnt: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !acc_gnt);

  // R9: self refresh acknowledged only with both strobes low
  a_r9_ack_strobes_low: assert property (@(posedge clk) disable iff (rst)
    sleep_ack |-> (!ras_n && !cas_n));

  // R3: init_done never falls once set
  a_r3_init_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(init_done) |-> init_done);
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int PAUSE    = 200;
  localparam int NINIT    = 8;
  localparam int INTERVAL = 40;
  localparam int FLIM     = 3;
  localparam int TCSR     = 2;
  localparam int TRAS     = 6;
  localparam int TRP      = 5;
  localparam int TRPS     = 11;
  localparam int SMIN     = 300;
  localparam int RW       = 10;
  localparam int MAXROW   = (1 << RW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_req = 1'b0, sleep_req = 1'b0, ras_only_sel = 1'b0;
  logic ras_n, cas_n, we_n, ref_busy, acc_gnt, init_done, sleep_ack;
  logic [RW-1:0] row_addr;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INIT_REFS(NINIT), .REF_INTERVAL(INTERVAL), .OWED_W(4),
    .FORCE_LIM(FLIM), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .T_RPS(TRPS),
    .SELF_MIN(SMIN), .ROW_W(RW)
  ) u_dut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .sleep_req(sleep_req),
    .ras_only_sel(ras_only_sel), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_addr(row_addr), .ref_busy(ref_busy), .acc_gnt(acc_gnt),
    .init_done(init_done), .sleep_ack(sleep_ack)
  );

  int total = 0, bad = 0;
  bit done_flag = 0;

  function automatic int next_row(input int r);
    return (r + 1) % (MAXROW + 1);
  endfunction

  function automatic int exp_refs(input int window);
    return window / INTERVAL;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  int cyc = 0, cas_run = 0, hi_run = 0, lo_run = 0;
  bit prev_ras = 1, first_done = 0, f_cbr = 0, ro_have = 0, pending_post = 0;
  int first_fall_cyc = 0, f_cyc = 0, f_cas_prev = 0, f_hi = 0, last_row = 0;
  int falls = 0, rises = 0, cbr_lead_bad = 0, cbr_hold_bad = 0, ras_len_bad = 0;
  int pre_bad = 0, ro_cas_bad = 0, ro_row_bad = 0, ro_cnt = 0, wraps = 0, we_bad = 0;
  int gnt_ras_bad = 0, gnt_early = 0, sr_cnt = 0, sr_pre_bad = 0, sr_lead_bad = 0;
  int post_bad = 0, post_seen = 0, last_ref_rise = 0, sr_rise_cyc = 0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (!we_n) we_bad++;
      if (acc_gnt && (!ras_n || !cas_n)) gnt_ras_bad++;
      if (acc_gnt && !init_done) gnt_early++;
      if (prev_ras && !ras_n) begin
        falls++;
        f_cyc = cyc; f_cas_prev = cas_run; f_hi = hi_run; f_cbr = !cas_n; lo_run = 0;
        if (!first_done) begin
          first_done = 1; first_fall_cyc = cyc;
        end else if (pending_post) begin
          if (f_hi < TRPS || cyc - sr_rise_cyc > INTERVAL) post_bad++;
          pending_post = 0; post_seen++;
        end else if (f_hi < TRP) pre_bad++;
        if (!f_cbr) begin
          ro_cnt++;
          if (ro_have) begin
            if (int'(row_addr) != next_row(last_row)) ro_row_bad++;
            if (last_row == MAXROW && row_addr == 0) wraps++;
          end
          last_row = int'(row_addr); ro_have = 1;
        end
      end
      if (!ras_n) begin
        lo_run++;
        if (!f_cbr && !cas_n) ro_cas_bad++;
        if (f_cbr && cas_n) cbr_hold_bad++;
      end
      if (!prev_ras && ras_n) begin
        rises++;
        if (lo_run >= SMIN) begin
          sr_cnt++;
          if (f_cyc - last_ref_rise > INTERVAL) sr_pre_bad++;
          if (f_cas_prev < TCSR) sr_lead_bad++;
          sr_rise_cyc = cyc; pending_post = 1;
        end else begin
          if (lo_run != TRAS) ras_len_bad++;
          if (f_cbr && f_cas_prev < TCSR) cbr_lead_bad++;
          last_ref_rise = cyc;
        end
      end
      cas_run  = cas_n ? 0 : cas_run + 1;
      hi_run   = ras_n ? hi_run + 1 : 0;
      prev_ras = ras_n;
    end
  end

  initial begin : main
    int f0, t0;
    void'($urandom(32'h5eed_0042));
    acc_req = 1'b1;                       // held from reset: exercises R3
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !acc_gnt && !init_done && !sleep_ack && ref_busy,
        "R1 reset state", {ras_n, cas_n, acc_gnt, init_done, sleep_ack, ref_busy}, 6'b110001);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !acc_gnt && !init_done, "R1 first cycle after reset",
        {ras_n, cas_n, acc_gnt, init_done}, 4'b1100);
    repeat (PAUSE - 20) @(negedge clk);
    chk(falls == 0 && ras_n, "R2 no RAS during pause", falls, 0);
    for (int i = 0; i < 1000 && !init_done; i++) @(negedge clk);
    chk(init_done, "R3 init_done reached", init_done, 1);
    chk(rises == NINIT, "R3 initial burst count", rises, NINIT);
    chk(first_fall_cyc >= PAUSE, "R2 first RAS fall after pause", first_fall_cyc, PAUSE);
    for (int i = 0; i < 50 && !acc_gnt; i++) @(negedge clk);
    chk(acc_gnt, "R7 grant after init", acc_gnt, 1);
    acc_req = 1'b0;
    @(negedge clk);

    // random accesses, each shorter than the interval
    f0 = falls; t0 = cyc;
    while (cyc - t0 < 2000) begin
      repeat ($urandom_range(0, 10)) @(negedge clk);
      acc_req = 1'b1;
      for (int i = 0; i < 200 && !acc_gnt; i++) @(negedge clk);
      repeat ($urandom_range(1, 30)) @(negedge clk);
      acc_req = 1'b0;
      @(negedge clk);
    end
    chk(falls - f0 >= exp_refs(2000) - 5, "R7 refreshes between accesses",
        falls - f0, exp_refs(2000) - 5);

    // idle window in CAS-before-RAS mode
    repeat (20) @(negedge clk);
    f0 = falls;
    repeat (400) @(negedge clk);
    chk((falls - f0 >= exp_refs(400) - 1) && (falls - f0 <= exp_refs(400) + 1),
        "R6 idle refresh rate", falls - f0, exp_refs(400));

    // RAS-only mode through a full row wrap
    ras_only_sel = 1'b1;
    for (int i = 0; i < 60000 && ro_cnt < MAXROW + 8; i++) @(negedge clk);
    chk(ro_cnt >= MAXROW + 8, "R5 RAS-only refresh count", ro_cnt, MAXROW + 8);
    chk(ro_row_bad == 0, "R5 row increments by one", ro_row_bad, 0);
    chk(wraps >= 1, "R5 row wraps 1023 to 0", wraps, 1);
    chk(ro_cas_bad == 0, "R5 CAS high during RAS-only", ro_cas_bad, 0);
    ras_only_sel = 1'b0;
    repeat (20) @(negedge clk);

    // back-to-back accesses: refresh must win by the owed limit
    f0 = falls; t0 = cyc;
    while (cyc - t0 < 1200) begin
      acc_req = 1'b1;
      for (int i = 0; i < 300 && !acc_gnt; i++) @(negedge clk);
      repeat (30) @(negedge clk);
      acc_req = 1'b0;
      @(negedge clk);
    end
    chk(falls - f0 >= exp_refs(1200) / 2, "R8 forced refresh under access stream",
        falls - f0, exp_refs(1200) / 2);
    acc_req = 1'b0;

    // self refresh entry and exit
    repeat (50) @(negedge clk);
    sleep_req = 1'b1;
    for (int i = 0; i < 300 && !sleep_ack; i++) @(negedge clk);
    chk(sleep_ack, "R9 sleep_ack rises", sleep_ack, 1);
    repeat (400) @(negedge clk);
    sleep_req = 1'b0;
    for (int i = 0; i < 100 && sleep_ack; i++) @(negedge clk);
    chk(!sleep_ack, "R9 sleep_ack falls on exit", sleep_ack, 0);
    repeat (100) @(negedge clk);
    chk(sr_cnt == 1, "R9 one self refresh of SELF_MIN or more", sr_cnt, 1);
    chk(sr_pre_bad == 0, "R9 refresh just before entry", sr_pre_bad, 0);
    chk(sr_lead_bad == 0, "R9 CAS leads RAS at entry", sr_lead_bad, 0);
    chk(post_seen == 1 && post_bad == 0, "R9 long precharge and refresh after exit",
        post_bad, 0);

    chk(we_bad == 0, "R10 write strobe high", we_bad, 0);
    chk(cbr_lead_bad == 0, "R4 CAS lead before RAS", cbr_lead_bad, 0);
    chk(cbr_hold_bad == 0, "R4 CAS held while RAS low", cbr_hold_bad, 0);
    chk(ras_len_bad == 0, "R4 RAS low width", ras_len_bad, 0);
    chk(pre_bad == 0, "R4 RAS precharge width", pre_bad, 0);
    chk(gnt_ras_bad == 0, "R7 strobes idle while granted", gnt_ras_bad, 0);
    chk(gnt_early == 0, "R3 no grant before init", gnt_early, 0);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule